// File: doc/BRIEF.md
# Register Bank and Stack Address Unit

This unit sits beside an 8-bit microcontroller core and owns two pieces of processor state: the program status byte and the one-byte stack pointer. It turns a three-bit working-register index into an internal-RAM byte address, using the two bank-select bits held in the status byte. It also produces the RAM address for each stack transfer and moves the stack pointer around that transfer.

The core reaches both registers through its special-function-register port, and reads are combinational. The ALU sends its carry, auxiliary-carry and overflow results in on a load strobe. The unit only stores these bits and does not compute them. The parity bit is not stored. It is derived from the accumulator input on every cycle.

For stack traffic the core raises one strobe per byte: push or call to store, pop or return to load. A call moves two bytes (low half of the return address first, then the high half) as two call strobes. A return undoes it with two return strobes.

Top module: `rbank_stack_addr`

## Requirements
- R1: After synchronous reset the stack pointer reads 0x07 and status bits 7 to 1 read zero.
- R2: Status bit 0 always equals the XOR of the eight accumulator bits, in the same cycle, on both `psw_out` and the SFR read port.
- R3: An SFR write to 0xD0 stores write-data bits 7 to 1 into the status byte, visible from the next cycle. Write-data bit 0 is discarded.
- R4: `reg_addr` equals {3'b000, status bits 4:3, `reg_idx`}, so bank values 0 to 3 map the registers to 0x00-0x07, 0x08-0x0F, 0x10-0x17 and 0x18-0x1F.
- R5: In a cycle with `stk_push` or `stk_call` high, `stk_addr` is SP+1, and SP holds SP+1 from the next cycle.
- R6: In a cycle with `stk_pop` or `stk_ret` high, `stk_addr` is the current SP, and SP holds SP-1 from the next cycle. With no strobe, `stk_addr` equals SP.
- R7: SP wraps modulo 256: a push at 0xFF addresses 0x00, and a pop at 0x00 leaves 0xFF.
- R8: An SFR write to 0x81 loads SP on the next cycle. If a stack strobe is high in the same cycle, the strobe wins and the write is dropped.
- R9: With `alu_flag_we` high, status bits 7, 6 and 2 load `alu_cy`, `alu_ac` and `alu_ov`. This takes priority over an SFR write to 0xD0 for those three bits.
- R10: SFR reads at any address other than 0xD0 and 0x81 return 0x00, and writes there change neither register.
- R11: Two consecutive call strobes address SP+1 and then SP+2 and leave SP advanced by two. Two return strobes then address SP+2 and SP+1 and restore SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Combinational SFR read data |
| acc | input | 8 | Current accumulator value |
| alu_flag_we | input | 1 | Load strobe for the ALU flags |
| alu_cy | input | 1 | Carry result |
| alu_ac | input | 1 | Auxiliary-carry result |
| alu_ov | input | 1 | Overflow result |
| reg_idx | input | 3 | Working-register index |
| reg_addr | output | 8 | RAM address of the indexed working register |
| stk_push | input | 1 | Push one byte |
| stk_call | input | 1 | Store one return-address byte |
| stk_pop | input | 1 | Pop one byte |
| stk_ret | input | 1 | Load one return-address byte |
| stk_addr | output | 8 | RAM address of the current stack transfer |
| psw_out | output | 8 | Status byte, with live parity in bit 0 |

## Verification
The assertions assume the core raises at most one of the four stack strobes in any cycle. A push-class strobe together with a pop-class strobe has no defined meaning here. The random stimulus therefore picks a single stack operation per cycle, or none, and never sets two strobes at once. Flag loads and SFR writes are left free to collide with stack strobes and with each other, so that the priority rules are exercised.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;
    localparam int BANK_W = 2;
    localparam int PAD_W  = BYTE_W - BANK_W - IDX_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic              cy;
        logic              ac;
        logic              f0;
        logic [BANK_W-1:0] bank;
        logic              ov;
        logic              uf;
        logic              par;
    } psw_t;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_UP   = 2'd1,
        STK_DOWN = 2'd2
    } stk_op_e;

    function automatic logic odd_ones(byte_t v);
        return ^v;
    endfunction

    function automatic byte_t bank_addr(logic [BANK_W-1:0] bank, logic [IDX_W-1:0] idx);
        return {{PAD_W{1'b0}}, bank, idx};
    endfunction
endpackage

// File: rtl/psw_reg.sv
module psw_reg
    import rbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wdata,
    input  byte_t acc,
    input  logic  flag_we,
    input  logic  cy_in,
    input  logic  ac_in,
    input  logic  ov_in,
    output psw_t  psw_o
);
    logic [BYTE_W-1:1] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (wr_en) begin
                st_q <= wdata[BYTE_W-1:1];
            end
            if (flag_we) begin
                st_q[7] <= cy_in;
                st_q[6] <= ac_in;
                st_q[2] <= ov_in;
            end
        end
    end

    assign psw_o = psw_t'({st_q, odd_ones(acc)});
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
    import rbs_pkg::*;
#(
    parameter byte_t RESET_VAL = 8'h07
) (
    input  logic    clk,
    input  logic    rst,
    input  stk_op_e op,
    input  logic    ld_en,
    input  byte_t   ld_val,
    output byte_t   sp_o,
    output byte_t   addr_o
);
    byte_t sp_q, sp_nxt;

    always_comb begin
        unique case (op)
            STK_UP: begin
                addr_o = sp_q + 8'd1;
                sp_nxt = sp_q + 8'd1;
            end
            STK_DOWN: begin
                addr_o = sp_q;
                sp_nxt = sp_q - 8'd1;
            end
            default: begin
                addr_o = sp_q;
                sp_nxt = ld_en ? ld_val : sp_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= RESET_VAL;
        else     sp_q <= sp_nxt;
    end

    assign sp_o = sp_q;
endmodule

// File: rtl/sfr_port.sv
module sfr_port
    import rbs_pkg::*;
#(
    parameter byte_t PSW_ADDR = 8'hD0,
    parameter byte_t SP_ADDR  = 8'h81
) (
    input  byte_t addr,
    input  logic  wr,
    input  psw_t  psw,
    input  byte_t sp,
    output logic  psw_we,
    output logic  sp_we,
    output byte_t rdata
);
    logic hit_psw, hit_sp;

    assign hit_psw = (addr == PSW_ADDR);
    assign hit_sp  = (addr == SP_ADDR);
    assign psw_we  = wr && hit_psw;
    assign sp_we   = wr && hit_sp;

    always_comb begin
        rdata = '0;
        if (hit_psw)     rdata = byte_t'(psw);
        else if (hit_sp) rdata = sp;
    end
endmodule

// File: rtl/rbank_stack_addr.sv
module rbank_stack_addr
    import rbs_pkg::*;
#(
    parameter logic [7:0] SP_RESET = 8'h07,
    parameter logic [7:0] PSW_SFR  = 8'hD0,
    parameter logic [7:0] SP_SFR   = 8'h81
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic [7:0] acc,
    input  logic       alu_flag_we,
    input  logic       alu_cy,
    input  logic       alu_ac,
    input  logic       alu_ov,
    input  logic [2:0] reg_idx,
    output logic [7:0] reg_addr,
    input  logic       stk_push,
    input  logic       stk_call,
    input  logic       stk_pop,
    input  logic       stk_ret,
    output logic [7:0] stk_addr,
    output logic [7:0] psw_out
);
    psw_t    psw;
    byte_t   sp_q;
    logic    psw_we, sp_we;
    stk_op_e op;

    always_comb begin
        if (stk_push || stk_call)     op = STK_UP;
        else if (stk_pop || stk_ret)  op = STK_DOWN;
        else                          op = STK_HOLD;
    end

    sfr_port #(.PSW_ADDR(PSW_SFR), .SP_ADDR(SP_SFR)) sfr_i (
        .addr(sfr_addr), .wr(sfr_wr), .psw(psw), .sp(sp_q),
        .psw_we(psw_we), .sp_we(sp_we), .rdata(sfr_rdata)
    );

    psw_reg psw_i (
        .clk(clk), .rst(rst), .wr_en(psw_we), .wdata(sfr_wdata), .acc(acc),
        .flag_we(alu_flag_we), .cy_in(alu_cy), .ac_in(alu_ac), .ov_in(alu_ov),
        .psw_o(psw)
    );

    stack_ptr #(.RESET_VAL(SP_RESET)) sp_i (
        .clk(clk), .rst(rst), .op(op), .ld_en(sp_we), .ld_val(sfr_wdata),
        .sp_o(sp_q), .addr_o(stk_addr)
    );

    assign reg_addr = bank_addr(psw.bank, reg_idx);
    assign psw_out  = byte_t'(psw);
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] acc,
    input logic [7:0] psw_out,
    input logic [7:0] sp,
    input logic [7:0] stk_addr,
    input logic [7:0] reg_addr,
    input logic [2:0] reg_idx,
    input logic [7:0] sfr_addr,
    input logic       sfr_wr,
    input logic       stk_push,
    input logic       stk_call,
    input logic       stk_pop,
    input logic       stk_ret
);
    logic up, down;
    assign up   = stk_push || stk_call;
    assign down = stk_pop || stk_ret;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stk_push, stk_call, stk_pop, stk_ret})); // R6
    AST_RESET_SP: assert property (@(posedge clk)
        rst |=> sp == 8'h07); // R1
    AST_PARITY_LIVE: assert property (@(posedge clk) disable iff (rst)
        psw_out[0] == ^acc); // R2
    AST_BANK_ADDR: assert property (@(posedge clk) disable iff (rst)
        reg_addr[7:5] == 3'b000 && reg_addr[4:3] == psw_out[4:3] && reg_addr[2:0] == reg_idx); // R4
    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (rst)
        up |-> stk_addr == 8'(sp + 8'd1)); // R5
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        up |=> sp == 8'($past(sp) + 8'd1)); // R5
    AST_POP_ADDR: assert property (@(posedge clk) disable iff (rst)
        down |-> stk_addr == sp); // R6
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        down |=> sp == 8'($past(sp) - 8'd1)); // R6
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!up && !down && !(sfr_wr && sfr_addr == 8'h81)) |=> $stable(sp)); // R8
endmodule

bind rbank_stack_addr rbs_checker chk_i (
    .clk(clk), .rst(rst), .acc(acc), .psw_out(psw_out), .sp(sp_q),
    .stk_addr(stk_addr), .reg_addr(reg_addr), .reg_idx(reg_idx),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .stk_push(stk_push),
    .stk_call(stk_call), .stk_pop(stk_pop), .stk_ret(stk_ret)
);

// File: tb/rbank_stack_addr_tb_top.sv
module rbank_stack_addr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = '0, sfr_wdata = '0, acc = '0;
    logic       sfr_wr = 1'b0, alu_flag_we = 1'b0, alu_cy = 1'b0, alu_ac = 1'b0, alu_ov = 1'b0;
    logic [2:0] reg_idx = '0;
    logic       stk_push = 1'b0, stk_call = 1'b0, stk_pop = 1'b0, stk_ret = 1'b0;
    logic [7:0] sfr_rdata, reg_addr, stk_addr, psw_out;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    logic [7:0] m_sp;
    logic [7:1] m_st;

    always #4 clk = ~clk;

    rbank_stack_addr dut_i (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .acc(acc),
        .alu_flag_we(alu_flag_we), .alu_cy(alu_cy), .alu_ac(alu_ac), .alu_ov(alu_ov),
        .reg_idx(reg_idx), .reg_addr(reg_addr), .stk_push(stk_push), .stk_call(stk_call),
        .stk_pop(stk_pop), .stk_ret(stk_ret), .stk_addr(stk_addr), .psw_out(psw_out)
    );

    function automatic logic [7:0] exp_psw(logic [7:1] st, logic [7:0] a);
        return {st, ^a};
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] ad, logic [7:1] st, logic [7:0] a, logic [7:0] sp);
        if (ad == 8'hD0) return exp_psw(st, a);
        if (ad == 8'h81) return sp;
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // strb = {push, call, pop, ret}
    task automatic step(string tag, logic [7:0] ad, logic wr, logic [7:0] wd, logic [7:0] a,
                        logic fwe, logic [2:0] fl, logic [2:0] idx, logic [3:0] strb);
        logic up, dn;
        @(negedge clk);
        sfr_addr = ad; sfr_wr = wr; sfr_wdata = wd; acc = a;
        alu_flag_we = fwe; {alu_cy, alu_ac, alu_ov} = fl; reg_idx = idx;
        {stk_push, stk_call, stk_pop, stk_ret} = strb;
        up = strb[3] | strb[2];
        dn = strb[1] | strb[0];
        #1;
        chk({tag, " stk_addr R5 R6"}, stk_addr, up ? 8'(m_sp + 8'd1) : m_sp);
        chk({tag, " reg_addr R4"}, reg_addr, {3'b000, m_st[4:3], idx});
        chk({tag, " psw_out R2"}, psw_out, exp_psw(m_st, a));
        chk({tag, " sfr_rdata R10"}, sfr_rdata, exp_rd(ad, m_st, a, m_sp));
        if (up)                        m_sp = m_sp + 8'd1;
        else if (dn)                   m_sp = m_sp - 8'd1;
        else if (wr && ad == 8'h81)    m_sp = wd;
        if (wr && ad == 8'hD0) m_st = wd[7:1];
        if (fwe) begin m_st[7] = fl[2]; m_st[6] = fl[1]; m_st[2] = fl[0]; end
        @(posedge clk);
    endtask

    task automatic idle(string tag, logic [7:0] ad);
        step(tag, ad, 1'b0, 8'h00, 8'h00, 1'b0, 3'b000, 3'd0, 4'b0000);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_sp = 8'h07; m_st = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset values
        idle("R1 sp", 8'h81);
        idle("R1 psw", 8'hD0);
        // R5 first push lands at 0x08
        step("R5 push", 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 3'b000, 3'd1, 4'b1000);
        idle("R5 after", 8'h81);
        // R11 call pair then return pair
        step("R11 call lo", 8'h81, 1'b0, 8'h00, 8'h01, 1'b0, 3'b000, 3'd2, 4'b0100);
        step("R11 call hi", 8'h81, 1'b0, 8'h00, 8'h03, 1'b0, 3'b000, 3'd2, 4'b0100);
        step("R11 ret hi", 8'h81, 1'b0, 8'h00, 8'h07, 1'b0, 3'b000, 3'd2, 4'b0001);
        step("R11 ret lo", 8'h81, 1'b0, 8'h00, 8'h0F, 1'b0, 3'b000, 3'd2, 4'b0001);
        // R6 pop
        step("R6 pop", 8'h81, 1'b0, 8'h00, 8'h00, 1'b0, 3'b000, 3'd0, 4'b0010);
        idle("R6 after", 8'h81);
        // R3 parity write ignored, bank select stored
        step("R3 wr", 8'hD0, 1'b1, 8'hFF, 8'h00, 1'b0, 3'b000, 3'd5, 4'b0000);
        step("R3 rd", 8'hD0, 1'b0, 8'h00, 8'h00, 1'b0, 3'b000, 3'd5, 4'b0000);
        step("R3 wr2", 8'hD0, 1'b1, 8'h09, 8'h01, 1'b0, 3'b000, 3'd7, 4'b0000);
        step("R3 rd2 R4", 8'hD0, 1'b0, 8'h00, 8'h01, 1'b0, 3'b000, 3'd7, 4'b0000);
        // R9 ALU flags win over SFR write
        step("R9 both", 8'hD0, 1'b1, 8'hFF, 8'h00, 1'b1, 3'b010, 3'd0, 4'b0000);
        idle("R9 rd", 8'hD0);
        // R7 wrap both ways
        step("R7 ld", 8'h81, 1'b1, 8'hFF, 8'h00, 1'b0, 3'b000, 3'd0, 4'b0000);
        step("R7 push wrap", 8'h81, 1'b0, 8'h00, 8'h00, 1'b0, 3'b000, 3'd0, 4'b1000);
        step("R7 pop wrap", 8'h81, 1'b0, 8'h00, 8'h00, 1'b0, 3'b000, 3'd0, 4'b0010);
        idle("R7 rd", 8'h81);
        // R8 strobe beats SFR load
        step("R8 clash", 8'h81, 1'b1, 8'h55, 8'h00, 1'b0, 3'b000, 3'd0, 4'b1000);
        idle("R8 rd", 8'h81);
        // R10 other addresses
        step("R10 wr", 8'h82, 1'b1, 8'hAA, 8'h00, 1'b0, 3'b000, 3'd0, 4'b0000);
        idle("R10 sp", 8'h81);
        idle("R10 psw", 8'hD0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ad;
            logic [3:0] strb;
            int pick;
            pick = $urandom_range(0, 3);
            ad = (pick == 0) ? 8'hD0 : (pick == 1) ? 8'h81 : 8'($urandom);
            pick = $urandom_range(0, 7);
            strb = (pick < 4) ? 4'(1 << pick) : 4'b0000;
            step("RND R5 R6 R7", ad, 1'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 3'($urandom), 3'($urandom), strb);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule